// File: doc/BRIEF.md
# Double-Buffered 8x8 Block Transposer

This block turns a stream of 8x8 sample blocks from row order into column order. Words arrive one per clock at most, marked by a valid strobe. They fill one of two 64-entry banks in row-major order. When the 64th word of a block lands, a read burst of that bank starts in the next cycle. It walks the bank in column-major order and emits one word per clock for 64 consecutive cycles. Meanwhile, the other bank takes the following block. The banks swap roles on every completed block.

The read side is a two-state machine. In RD_IDLE it waits for a block to complete. On a block-complete event it takes the transition IDLE->RUN and latches the bank that just filled. In RD_RUN it steps a 6-bit read counter and holds its state until the counter reaches 63. At that count it takes one of two transitions:

- RUN->RUN (reload) if another block completes in that same cycle. This happens when the input is back-to-back.
- RUN->IDLE otherwise.

The write side is a plain counter with a bank-select bit. The counter advances only on valid input, and the bank bit flips each time the counter wraps. The matrix side is a parameter and must be a power of two.

Top module: `xpose_pingpong`

## Requirements
- R1: While rst_n is low and in the cycle after its release, out_valid is 0 and out_data is 0. The first valid word after reset is element 0 of a new block.
- R2: Each cycle with in_valid=1 stores in_data as block element row*8+col, in row-major arrival order. Cycles with in_valid=0 are ignored, whatever in_data holds, and do not advance the element count.
- R3: Output word j of a block (j = 0..63) equals input element (j mod 8)*8 + (j div 8), which is column-major order.
- R4: The first output word of a block is valid two cycles after the cycle that carried its 64th input word. With gapless input this is 65 cycles after its first input word.
- R5: Each block produces exactly 64 cycles of out_valid=1. These cycles are consecutive, and out_valid is 0 whenever no block is being read.
- R6: With back-to-back input blocks, the next block is written into the other bank while the current one is read. The output stream is then contiguous: block b+1 starts 64 cycles after block b, with no corruption.
- R7: Input with idle cycles inside a block, including long pauses, still yields the correct column-order data for that block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | DATA_W | Input sample, row-major order |
| out_valid | output | 1 | Output word strobe |
| out_data | output | DATA_W | Output sample, column-major order |

## Verification
The hardest case to reach from the ports is a block completing in the same cycle that the previous read burst emits its last word. This forces the RUN->RUN reload while the write and read banks swap.

The stimulus sends four gapless blocks in a row, so the reload happens three times. It then sends blocks with regularly spaced idle cycles and a long mid-block pause, carrying junk data on the idle cycles. Every word is compared against an arithmetic transpose, and every output word's cycle is compared against the expected burst timing.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;
endpackage

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              blk_done
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    logic [ADDR_W-1:0] wr_cnt;

    assign wr_addr  = wr_cnt;
    assign blk_done = in_valid && (wr_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt  <= '0;
            wr_bank <= 1'b0;
        end else if (in_valid) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt == LAST) begin
                wr_bank <= ~wr_bank;
            end
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_cnt)); // R2
endmodule

// File: rtl/xpose_rd_ctrl.sv
module xpose_rd_ctrl
    import xpose_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_bank,
    output logic                rd_en,
    output logic                rd_bank,
    output logic [2*IDX_W-1:0]  rd_addr,
    output logic                out_valid
);
    localparam int ADDR_W = 2 * IDX_W;
    localparam logic [ADDR_W-1:0] LAST = '1;

    rd_state_t         state, state_nx;
    logic [ADDR_W-1:0] rd_cnt, cnt_nx;
    logic              bank_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RD_IDLE;
            rd_cnt    <= '0;
            rd_bank   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            state     <= state_nx;
            rd_cnt    <= cnt_nx;
            rd_bank   <= bank_nx;
            out_valid <= rd_en;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = rd_cnt;
        bank_nx  = rd_bank;
        unique case (state)
            RD_IDLE: begin
                if (start) begin
                    state_nx = RD_RUN;
                    cnt_nx   = '0;
                    bank_nx  = start_bank;
                end
            end
            RD_RUN: begin
                if (rd_cnt == LAST) begin
                    cnt_nx = '0;
                    if (start) begin
                        bank_nx = start_bank;
                    end else begin
                        state_nx = RD_IDLE;
                    end
                end else begin
                    cnt_nx = rd_cnt + 1'b1;
                end
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    assign rd_en   = (state == RD_RUN);
    // counter holds col in its upper field and row in its lower field
    assign rd_addr = {rd_cnt[IDX_W-1:0], rd_cnt[ADDR_W-1:IDX_W]};

    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == RD_RUN && rd_cnt == '0)); // R4
    AST_BURST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_RUN && rd_cnt != LAST) |=> state == RD_RUN); // R5
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == RD_RUN) |-> rd_cnt == LAST); // R6
endmodule

// File: rtl/xpose_bank_mem.sv
module xpose_bank_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ENTRIES = 2 * (1 << ADDR_W);

    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wbank, waddr}] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[{rbank, raddr}];
        end
    end
endmodule

// File: rtl/xpose_pingpong.sv
module xpose_pingpong #(
    parameter int DATA_W = 8,
    parameter int DIM    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int IDX_W  = $clog2(DIM);
    localparam int ADDR_W = 2 * IDX_W;

    logic              wr_bank, blk_done;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_en, rd_bank;
    logic [ADDR_W-1:0] rd_addr;

    xpose_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_bank  (wr_bank),
        .wr_addr  (wr_addr),
        .blk_done (blk_done)
    );

    xpose_rd_ctrl #(.IDX_W(IDX_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (blk_done),
        .start_bank (wr_bank),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid)
    );

    xpose_bank_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_valid),
        .wbank (wr_bank),
        .waddr (wr_addr),
        .wdata (in_data),
        .re    (rd_en),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (out_data)
    );

    AST_BANK_APART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_bank != wr_bank); // R6
endmodule

// File: tb/xpose_pingpong_bench.sv
module xpose_pingpong_bench;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int NBLK   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nout = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [DATA_W-1:0] out_word [NBLK*64];
    int                out_cyc  [NBLK*64];
    int                first_cyc [NBLK];
    int                last_cyc  [NBLK];

    xpose_pingpong #(.DATA_W(DATA_W), .DIM(8)) u_xpose_pingpong (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] val(int b, int i);
        return DATA_W'((b * 37 + i * 5 + 3) & 8'hFF);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (nout < NBLK*64) begin
                out_word[nout] = out_data;
                out_cyc[nout]  = cyc;
            end
            nout++;
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 8'hA5;
        end
    endtask

    task automatic send_block(int b, bit gaps);
        for (int i = 0; i < 64; i++) begin
            if (gaps && (i % 3 == 1)) idle(1);
            if (gaps && i == 30) idle(100);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = val(b, i);
            if (i == 0)  first_cyc[b] = cyc;
            if (i == 63) last_cyc[b]  = cyc;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_data == '0, "R1", int'(out_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        idle(5);
        for (int b = 0; b < 4; b++) send_block(b, 1'b0);
        idle(120);
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        send_block(4, 1'b1);
        send_block(5, 1'b1);
        idle(150);
        check(nout == NBLK*64, "R5", nout, NBLK*64);
        if (nout >= NBLK*64) begin
            for (int b = 0; b < NBLK; b++) begin
                for (int k = 0; k < 64; k++) begin
                    logic [DATA_W-1:0] e;
                    e = val(b, (k % 8) * 8 + k / 8);
                    check(out_word[b*64+k] == e, (b < 4) ? "R3" : "R7",
                          int'(out_word[b*64+k]), int'(e));
                    check(out_cyc[b*64+k] == out_cyc[b*64] + k, "R5",
                          out_cyc[b*64+k], out_cyc[b*64] + k);
                end
                check(out_cyc[b*64] == last_cyc[b] + 2, "R4",
                      out_cyc[b*64], last_cyc[b] + 2);
                if (b < 4) begin
                    check(out_cyc[b*64] == first_cyc[b] + 65, "R4",
                          out_cyc[b*64], first_cyc[b] + 65);
                end
                if (b >= 1 && b < 4) begin
                    check(out_cyc[b*64] == out_cyc[(b-1)*64] + 64, "R6",
                          out_cyc[b*64], out_cyc[(b-1)*64] + 64);
                end
            end
            check(first_cyc[4] > last_cyc[3], "R2", first_cyc[4], last_cyc[3] + 1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule